// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block holds the host-visible event flags of an Ethernet MAC controller and turns them into one active-low interrupt line. Six sources feed it: transmit done, receive done, bus-grant timeout (memory error), missed frame, collision error and babble. Each event is caught in a sticky flag that stays set until the host writes a 1 to it. A per-flag mask register and a master enable decide which flags may pull the interrupt low. Two of the sources are detected inside the block. A byte counter flags an oversized transmit frame. A grant watchdog flags a bus request that has waited too long, and the host can program how long.

The host reaches the block through a small synchronous register port. Writes happen on the clock edge and reads are combinational. A stop command bit and a synchronous soft reset both wipe the flags. An asynchronous hard reset returns everything to its reset state. The block also drives a summary error output and a saturating count of missed frames.

Top module: `nic_irq_status`

## Requirements
- R1: A set flag stays set. Writing 1 to its bit of the status register (address 0; bit 0 transmit, bit 1 receive, bit 2 memory error, bit 3 missed frame, bit 4 collision, bit 5 babble) clears it. Writing 0 leaves it unchanged.
- R2: When a source event and a write-1-to-clear of the same flag happen in the same cycle, the flag is set after that edge.
- R3: Writing 1 to bit 2 of the control register (address 2) clears all flags, and this bit reads back 0. A soft reset pulse also clears all flags. Hard reset clears flags, mask, control and the missed-frame count. Stop and soft reset take priority over events in the same cycle.
- R4: irq_n is low exactly when the enable (control bit 0) is 1 and some transmit, receive, memory-error, missed-frame or babble flag is set while its mask bit (address 1, same bit positions) is 0. irq_n goes high in the cycle after the write that clears the last such flag.
- R5: The collision flag never drives irq_n low. Its mask bit is not stored and reads 0.
- R6: Status bit 7 and the err_any output are 1 while any of the babble, collision, missed-frame or memory-error flags is set, independent of enable and mask. Status bit 6 reads 0.
- R7: The babble flag sets on the 1519th tx_byte strobe of a frame. A tx_sof strobe starts a new frame, and tx_byte in the same cycle counts as that frame's first byte. A frame of 1518 bytes does not set the flag.
- R8: miss_count increments by one for every cycle in which ev_miss is high. It saturates at 16'hFFFF, and only hard reset clears it.
- R9: The receive flag sets on ev_rx_last. It also sets on ev_rx_first only when the early-receive bit (control bit 1) is 1.
- R10: The memory-error flag sets at the edge that ends the Nth consecutive cycle with bus_req high and bus_gnt low, where N is the value of register address 3. A grant or a dropped request restarts the count. N = 0 disables the watchdog.
- R11: After hard reset the status, mask and control registers read 0, register 3 reads 1690, irq_n is high and miss_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for addr |
| ev_coll | input | 1 | Collision error event |
| ev_miss | input | 1 | Missed frame event |
| ev_rx_last | input | 1 | Last receive descriptor returned |
| ev_rx_first | input | 1 | First receive descriptor returned |
| ev_tx_done | input | 1 | Transmit frame finished |
| tx_sof | input | 1 | Start of transmit frame |
| tx_byte | input | 1 | One transmit byte sent |
| bus_req | input | 1 | Bus request pending |
| bus_gnt | input | 1 | Bus grant |
| irq_n | output | 1 | Interrupt, active low |
| err_any | output | 1 | Summary error flag |
| miss_count | output | 16 | Saturating missed-frame count |

## Verification
The hardest states to reach from the ports are the babble threshold and missed-frame saturation, which need long runs. The stimulus streams 1518 and then 1519 byte strobes inside one frame. It then holds ev_miss high for more than 65,535 cycles and checks the count at its ceiling, again after a soft reset, and once more after hard reset. The watchdog boundary is reached by holding a request ungranted for one cycle less than the programmed limit and then for exactly the limit. A grant inserted part way through is used to show that the count restarts. The interrupt gating is swept over every mask value, both enable states and several single-flag sources.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
    localparam int NFLAG  = 6;
    localparam int DATA_W = 16;
    localparam int TMO_W  = 16;

    localparam int F_TX   = 0;
    localparam int F_RX   = 1;
    localparam int F_MEM  = 2;
    localparam int F_MISS = 3;
    localparam int F_COLL = 4;
    localparam int F_BABL = 5;

    localparam int ERR_BIT  = 7;
    localparam int STOP_BIT = 2;

    // flags allowed to reach the interrupt line
    localparam logic [NFLAG-1:0] IRQ_CAPABLE = 6'b101111;
    // flags feeding the summary error bit
    localparam logic [NFLAG-1:0] ERR_GROUP   = 6'b111100;

    typedef enum logic [1:0] {
        A_STATUS = 2'd0,
        A_MASK   = 2'd1,
        A_CTRL   = 2'd2,
        A_TMO    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [NFLAG-1:0] mask;
        logic             irq_en;
        logic             early_rx;
        logic [TMO_W-1:0] tmo_limit;
    } regs_t;
endpackage

// File: rtl/nic_babble_det.sv
module nic_babble_det #(
    parameter  int LIMIT = 1519,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tx_sof,
    input  logic tx_byte,
    output logic hit
);
    logic [CW-1:0] cnt_q, cnt_d, base;

    always_comb begin
        base  = tx_sof ? '0 : cnt_q;
        cnt_d = base;
        hit   = 1'b0;
        if (tx_byte && base != CW'(LIMIT)) begin
            cnt_d = base + 1'b1;
            hit   = (cnt_d == CW'(LIMIT));
        end
        if (clr) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nic_gnt_watchdog.sv
module nic_gnt_watchdog #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bus_req,
    input  logic         bus_gnt,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q, cnt_d;
    logic         waiting;

    always_comb begin
        waiting = bus_req && !bus_gnt;
        hit     = waiting && (limit != '0) && (cnt_q == limit - W'(1));
        if (!waiting || clr)   cnt_d = '0;
        else if (cnt_q < limit) cnt_d = cnt_q + W'(1);
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nic_sat_counter.sv
module nic_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] count_q, count_d;

    always_comb begin
        count_d = count_q;
        if (inc && count_q != '1) count_d = count_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import nic_irq_pkg::*;
#(
    parameter int BABBLE_BYTES = 1519,
    parameter int CNT_W        = 16,
    parameter int TMO_RESET    = 1690
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_coll,
    input  logic              ev_miss,
    input  logic              ev_rx_last,
    input  logic              ev_rx_first,
    input  logic              ev_tx_done,
    input  logic              tx_sof,
    input  logic              tx_byte,
    input  logic              bus_req,
    input  logic              bus_gnt,
    output logic              irq_n,
    output logic              err_any,
    output logic [CNT_W-1:0]  miss_count
);
    regs_t            st_q, st_d;
    logic             babble_hit, tmo_hit, stop_cmd, wipe;
    logic [NFLAG-1:0] set_vec, clr_vec;

    nic_babble_det #(.LIMIT(BABBLE_BYTES)) u_babble (
        .clk(clk), .rst_n(rst_n), .clr(wipe),
        .tx_sof(tx_sof), .tx_byte(tx_byte), .hit(babble_hit)
    );

    nic_gnt_watchdog #(.W(TMO_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .clr(wipe),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .limit(st_q.tmo_limit), .hit(tmo_hit)
    );

    nic_sat_counter #(.W(CNT_W)) u_miss_cnt (
        .clk(clk), .rst_n(rst_n), .inc(ev_miss), .count(miss_count)
    );

    always_comb begin
        st_d     = st_q;
        stop_cmd = wr_en && (addr == A_CTRL) && wdata[STOP_BIT];
        wipe     = stop_cmd || soft_rst;
        clr_vec  = (wr_en && addr == A_STATUS) ? wdata[NFLAG-1:0] : '0;

        set_vec         = '0;
        set_vec[F_TX]   = ev_tx_done;
        set_vec[F_RX]   = ev_rx_last || (st_q.early_rx && ev_rx_first);
        set_vec[F_MEM]  = tmo_hit;
        set_vec[F_MISS] = ev_miss;
        set_vec[F_COLL] = ev_coll;
        set_vec[F_BABL] = babble_hit;

        st_d.flags = (st_q.flags & ~clr_vec) | set_vec;

        if (wr_en) begin
            unique case (addr)
                A_MASK:   st_d.mask = wdata[NFLAG-1:0] & IRQ_CAPABLE;
                A_CTRL: begin
                    st_d.irq_en   = wdata[0];
                    st_d.early_rx = wdata[1];
                end
                A_TMO:    st_d.tmo_limit = wdata[TMO_W-1:0];
                default:  ;
            endcase
        end

        if (wipe) st_d.flags = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.tmo_limit <= TMO_W'(TMO_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        irq_n   = ~(st_q.irq_en && |(st_q.flags & ~st_q.mask & IRQ_CAPABLE));
        err_any = |(st_q.flags & ERR_GROUP);
        rdata   = '0;
        unique case (addr)
            A_STATUS: begin
                rdata[NFLAG-1:0] = st_q.flags;
                rdata[ERR_BIT]   = err_any;
            end
            A_MASK:   rdata[NFLAG-1:0] = st_q.mask;
            A_CTRL:   rdata[1:0]       = {st_q.early_rx, st_q.irq_en};
            A_TMO:    rdata[TMO_W-1:0] = st_q.tmo_limit;
            default:  ;
        endcase
    end
endmodule

// File: rtl/nic_irq_status_chk.sv
module nic_irq_status_chk
    import nic_irq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic              ev_coll,
    input logic              ev_miss,
    input logic              ev_tx_done,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              irq_n,
    input logic              err_any,
    input logic [CNT_W-1:0]  miss_count,
    input regs_t             st_q,
    input logic              stop_cmd,
    input logic              babble_hit,
    input logic              tmo_hit
);
    a_r2_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_done && !stop_cmd && !soft_rst |=> st_q.flags[F_TX]);

    a_r1_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flags[F_RX] && !(wr_en && addr == A_STATUS && wdata[F_RX])
        && !stop_cmd && !soft_rst |=> st_q.flags[F_RX]);

    a_r3_stop_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> st_q.flags == '0);

    a_r5_coll_alone_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flags & ~(NFLAG'(1) << F_COLL)) == '0 |-> irq_n);

    a_r6_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_any) |-> $past(ev_coll || ev_miss || babble_hit || tmo_hit));

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        ev_miss && miss_count != '1 |=> miss_count == $past(miss_count) + CNT_W'(1));

    a_r8_count_holds_max: assert property (@(posedge clk) disable iff (!rst_n)
        miss_count == '1 |=> miss_count == '1);

    a_r10_hit_only_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |-> bus_req && !bus_gnt);
endmodule

bind nic_irq_status nic_irq_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .ev_coll(ev_coll), .ev_miss(ev_miss),
    .ev_tx_done(ev_tx_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .irq_n(irq_n), .err_any(err_any), .miss_count(miss_count),
    .st_q(st_q), .stop_cmd(stop_cmd), .babble_hit(babble_hit),
    .tmo_hit(tmo_hit)
);

// File: tb/nic_irq_status_bench.sv
module nic_irq_status_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0, rdata;
    logic        ev_coll = 0, ev_miss = 0, ev_rx_last = 0, ev_rx_first = 0, ev_tx_done = 0;
    logic        tx_sof = 0, tx_byte = 0, bus_req = 0, bus_gnt = 0;
    logic        irq_n, err_any;
    logic [15:0] miss_count;

    int checks = 0, failures = 0;
    int exp_miss = 0;
    logic [15:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_irq_status u_nic_irq_status (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ev_coll(ev_coll),
        .ev_miss(ev_miss), .ev_rx_last(ev_rx_last), .ev_rx_first(ev_rx_first),
        .ev_tx_done(ev_tx_done), .tx_sof(tx_sof), .tx_byte(tx_byte),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .irq_n(irq_n),
        .err_any(err_any), .miss_count(miss_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // 0 tx_done, 1 rx_last, 2 rx_first, 3 miss, 4 coll
    task automatic pulse(input int which);
        case (which)
            0: ev_tx_done = 1'b1;
            1: ev_rx_last = 1'b1;
            2: ev_rx_first = 1'b1;
            3: begin ev_miss = 1'b1; exp_miss++; end
            default: ev_coll = 1'b1;
        endcase
        @(negedge clk);
        ev_tx_done = 0; ev_rx_last = 0; ev_rx_first = 0; ev_miss = 0; ev_coll = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(0, v); chk("R11 status", v, 16'h0);
        rd(1, v); chk("R11 mask", v, 16'h0);
        rd(2, v); chk("R11 ctrl", v, 16'h0);
        rd(3, v); chk("R11 tmo", v, 16'd1690);
        chk("R11 irq_n", irq_n, 1'b1);
        chk("R11 miss_count", miss_count, 16'h0);

        // R4 R5 R6 sweep: one source at a time, every mask, both enables
        for (int s = 0; s < 4; s++) begin
            int src, bitpos;
            src    = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 3 : 4;
            bitpos = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 3 : 4;
            wr(2, 16'h0);
            wr(0, 16'h003F);
            pulse(src);
            rd(0, v);
            chk("R6 status single flag", v,
                16'((1 << bitpos) | ((bitpos >= 2) ? 16'h80 : 16'h0)));
            chk("R6 err_any", err_any, logic'(bitpos >= 2));
            for (int en = 0; en < 2; en++) begin
                for (int m = 0; m < 64; m++) begin
                    wr(1, 16'(m));
                    wr(2, 16'(en));
                    chk("R4 R5 irq gating", irq_n,
                        !(en == 1 && bitpos != 4 && ((m >> bitpos) & 1) == 0));
                    if (en == 0) begin
                        rd(1, v); chk("R5 mask readback", v, 16'(m & 6'b101111));
                    end
                end
            end
        end

        // R1 write-one-to-clear and R4 deassert timing
        wr(2, 16'h0); wr(1, 16'h0); wr(0, 16'h003F);
        pulse(0); pulse(1);
        wr(0, 16'h0);
        rd(0, v); chk("R1 write zero keeps", v, 16'h0003);
        wr(0, 16'h0001);
        rd(0, v); chk("R1 clear tx only", v, 16'h0002);
        wr(2, 16'h0001);
        chk("R4 irq low", irq_n, 1'b0);
        wr(0, 16'h0002);
        chk("R4 irq high after clear", irq_n, 1'b1);

        // R2 event and clear in same cycle
        ev_tx_done = 1'b1;
        wr(0, 16'h0001);
        ev_tx_done = 1'b0;
        rd(0, v); chk("R2 event wins", v, 16'h0001);

        // R3 stop command and soft reset
        pulse(1); pulse(4);
        wr(1, 16'h0021);
        wr(2, 16'h0005);
        rd(0, v); chk("R3 stop clears", v, 16'h0);
        rd(2, v); chk("R3 stop reads zero", v, 16'h0001);
        ev_tx_done = 1'b1;
        wr(2, 16'h0005);
        ev_tx_done = 1'b0;
        rd(0, v); chk("R3 stop beats event", v, 16'h0);
        pulse(0); pulse(3);
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        rd(0, v); chk("R3 soft reset clears", v, 16'h0);
        rd(1, v); chk("R3 soft reset keeps mask", v, 16'h0021);
        wr(1, 16'h0);

        // R9 early receive
        wr(2, 16'h0000);
        pulse(2);
        rd(0, v); chk("R9 first ignored", v, 16'h0);
        wr(2, 16'h0002);
        pulse(2);
        rd(0, v); chk("R9 first with early", v, 16'h0002);
        wr(0, 16'h003F);

        // R10 grant watchdog, limit 5
        wr(2, 16'h0);
        wr(3, 16'd5);
        bus_req = 1'b1;
        repeat (4) @(negedge clk);
        rd(0, v); chk("R10 before limit", v, 16'h0);
        @(negedge clk);
        rd(0, v); chk("R10 at limit R6 err", v, 16'h0084);
        chk("R6 err with irq off", err_any, 1'b1);
        bus_req = 1'b0;
        wr(0, 16'h003F);
        bus_req = 1'b1;
        repeat (3) @(negedge clk);
        bus_gnt = 1'b1; @(negedge clk); bus_gnt = 1'b0;
        repeat (4) @(negedge clk);
        rd(0, v); chk("R10 grant restarts", v, 16'h0);
        @(negedge clk);
        rd(0, v); chk("R10 after restart", v, 16'h0084);
        bus_req = 1'b0;
        wr(0, 16'h003F);
        wr(3, 16'd0);
        bus_req = 1'b1;
        repeat (20) @(negedge clk);
        rd(0, v); chk("R10 zero disables", v, 16'h0);
        bus_req = 1'b0;

        // R7 babble at 1519 bytes
        for (int fr = 0; fr < 2; fr++) begin
            tx_sof = 1'b1; tx_byte = 1'b1;
            @(negedge clk);
            tx_sof = 1'b0;
            repeat (1517) @(negedge clk);
            tx_byte = 1'b0;
            rd(0, v); chk("R7 1518 bytes no babble", v, 16'h0);
        end
        tx_byte = 1'b1;
        @(negedge clk);
        tx_byte = 1'b0;
        rd(0, v); chk("R7 byte 1519 babble", v, 16'h00A0);
        wr(2, 16'h0001);
        chk("R4 babble interrupts", irq_n, 1'b0);
        wr(2, 16'h0000);
        wr(0, 16'h003F);

        // R8 missed-frame count and saturation
        chk("R8 count so far", miss_count, 16'(exp_miss));
        ev_miss = 1'b1;
        repeat (65600) @(negedge clk);
        ev_miss = 1'b0;
        chk("R8 saturated", miss_count, 16'hFFFF);
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        chk("R8 soft reset keeps count", miss_count, 16'hFFFF);

        // R3 R11 hard reset
        pulse(0);
        wr(2, 16'h0003);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        rd(0, v); chk("R3 hard reset flags", v, 16'h0);
        rd(2, v); chk("R11 hard reset ctrl", v, 16'h0);
        chk("R8 hard reset count", miss_count, 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule